// File: doc/BRIEF.md
# Prescaler Reset and Synchronization Control

This block has two free-running clock prescalers and the byte-wide control register that restarts them. The synchronous prescaler runs on the system clock and serves four timers through one set of enable taps. The asynchronous prescaler runs on a separate clock and serves one timer that can be switched into an asynchronous mode. Software writes a one to a request bit to restart either prescaler. A hold bit keeps both restart requests latched, so the timers stay frozen while they are loaded with matching values. When the hold bit is cleared, both prescalers resume on the same system cycle.

The request for the asynchronous prescaler crosses into the other clock domain through a two-flop synchronizer. It stays raised until an acknowledge returns through a second two-flop synchronizer, so the far side sees every request however slow its clock is. While the timer is in asynchronous mode, the software-visible request bit also stays set until that acknowledge arrives.

Top module: `psc_sync_ctrl`

## Requirements
- R1: After reset the control register reads 0x00. Bits 6 to 2 always read as zero.
- R2: The register is written and read at data-space address 0x43 when `bus_io_sel` is 0, and at I/O-space address 0x23 when `bus_io_sel` is 1. Any other address, or a mismatched space, leaves the register unchanged and reads back 0x00.
- R3: With the hold bit (bit 7) clear, writing 1 to bit 0 raises `sync_psc_rst_o` for exactly one system cycle. Bit 0 reads 1 in that cycle and 0 in the next.
- R4: `sync_tick_o[0..3]` pulse for one cycle once every 8, 64, 256 and 1024 system cycles respectively. While the synchronous prescaler is in reset they are all zero, and all four phases restart together.
- R5: While bit 7 is 1, a 1 written to bit 0 is kept and `sync_psc_rst_o` stays high for as long as it is kept.
- R6: Writing bit 7 to 0 clears bits 0 and 1 together one cycle after the write. The synchronous reset then drops in that cycle.
- R7: With `async_mode_i` low and bit 7 clear, bit 1 clears on the cycle after it was written. The asynchronous prescaler is still reset: `async_psc_rst_o` rises afterwards.
- R8: With `async_mode_i` high, bit 1 stays set until `async_psc_rst_o` has been asserted in the asynchronous domain. It then clears without software action.
- R9: Hardware never clears bit 1 while bit 7 is 1, in either mode.
- R10: When a register write falls in the same cycle as a hardware self-clear, the written value wins.
- R11: Writes to bits 6 to 2 have no effect.
- R12: `async_tick_o[0..5]` pulse once every 8, 32, 64, 128, 256 and 1024 `aclk` cycles respectively, and are zero while `async_psc_rst_o` holds the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System-domain reset, active low, asynchronous assert |
| aclk | input | 1 | Clock of the asynchronous prescaler |
| arst_n | input | 1 | Asynchronous-domain reset, active low |
| bus_io_sel | input | 1 | 1 selects I/O-space decoding, 0 selects data-space decoding |
| bus_addr | input | 16 | Register bus address |
| bus_we | input | 1 | Write strobe, one system cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, 0x00 when not selected |
| async_mode_i | input | 1 | The asynchronous timer runs in asynchronous mode |
| sync_psc_rst_o | output | 1 | Reset applied to the synchronous prescaler |
| sync_tick_o | output | 4 | Synchronous prescaler enables: /8, /64, /256, /1024 |
| async_psc_rst_o | output | 1 | Reset applied to the asynchronous prescaler (aclk domain) |
| async_tick_o | output | 6 | Asynchronous prescaler enables: /8, /32, /64, /128, /256, /1024 |

## Verification
The restart register is driven with single writes and back-to-back writes. Single writes show the one-cycle self-clear, and back-to-back writes separate write priority from self-clear. Held writes under the hold bit are followed by a release write. They tell a latched request from a pulsed one and show that both bits clear in the same cycle on release. The asynchronous request is exercised with the mode input low and then high, which separates the immediate clear from the clear that waits for the far domain. Writes at the I/O alias, at a neighbouring address and with the wrong space select check the decode.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
  parameter int unsigned   BUS_AW         = 16;
  parameter logic [15:0]   CTL_DATA_ADDR  = 16'h0043;
  parameter logic [15:0]   IO_WINDOW_BASE = 16'h0020;
  parameter int unsigned   HOLD_BIT       = 7;
  parameter int unsigned   AREQ_BIT       = 1;
  parameter int unsigned   SREQ_BIT       = 0;

  typedef struct packed {
    logic hold;
    logic areq;
    logic sreq;
  } psc_ctl_t;
endpackage

// File: rtl/psc_rst_sync.sv
`timescale 1ns/1ps
module psc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/psc_cdc_sync.sv
`timescale 1ns/1ps
module psc_cdc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/psc_counter.sv
`timescale 1ns/1ps
module psc_counter #(
  parameter int unsigned           CNT_W    = 10,
  parameter int unsigned           NTAP     = 4,
  parameter logic [NTAP*8-1:0]     TAP_LOG2 = {8'd10, 8'd8, 8'd6, 8'd3}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  output logic [NTAP-1:0] tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    if (clr_i) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int unsigned      SH  = int'(TAP_LOG2[g*8 +: 8]);
    localparam logic [CNT_W-1:0] MSK = CNT_W'((1 << SH) - 1);
    assign tick_o[g] = ((cnt_q & MSK) == MSK);
  end

  AST_TICKS_QUIET_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (tick_o == '0)); // R4, R12
  AST_FREE_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R4, R12
endmodule

// File: rtl/psc_ctl_reg.sv
`timescale 1ns/1ps
module psc_ctl_reg
  import psc_pkg::*;
#(
  parameter int unsigned        ADDR_W    = BUS_AW,
  parameter logic [ADDR_W-1:0]  DATA_ADDR = ADDR_W'(CTL_DATA_ADDR),
  parameter logic [ADDR_W-1:0]  IO_BASE   = ADDR_W'(IO_WINDOW_BASE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              async_mode_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              sreq_o
);
  localparam logic [ADDR_W-1:0] IO_ADDR = DATA_ADDR - IO_BASE;

  psc_ctl_t cur_q, cur_d;
  logic     req_q, req_d;
  logic     pend_q, pend_d;
  logic     sel, wr_hit, ack_done, want;
  logic     unused_wbits;

  assign unused_wbits = ^wdata_i[6:2];

  // address decode: the I/O window aliases the data-space address
  always_comb begin
    sel    = io_sel_i ? (addr_i == IO_ADDR) : (addr_i == DATA_ADDR);
    wr_hit = we_i && sel;
  end

  // next state of the software-visible bits
  always_comb begin
    ack_done = req_q && ack_i;
    cur_d    = cur_q;
    if (!cur_q.hold) begin
      cur_d.sreq = 1'b0;
      if (!async_mode_i || ack_done) cur_d.areq = 1'b0;
    end
    if (wr_hit) begin
      cur_d.hold = wdata_i[HOLD_BIT];
      cur_d.areq = wdata_i[AREQ_BIT];
      cur_d.sreq = wdata_i[SREQ_BIT];
    end
  end

  // four-phase request toward the other domain
  always_comb begin
    want = cur_q.areq || pend_q;
    if (req_q) req_d = cur_q.areq || !ack_i;
    else       req_d = want && !ack_i;
    pend_d = !req_q && !req_d && want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel) begin
      rdata_o[HOLD_BIT] = cur_q.hold;
      rdata_o[AREQ_BIT] = cur_q.areq;
      rdata_o[SREQ_BIT] = cur_q.sreq;
    end
  end

  assign req_o  = req_q;
  assign sreq_o = cur_q.sreq;

  AST_SREQ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.sreq && !cur_q.hold && !wr_hit |=> !cur_q.sreq); // R3
  AST_SREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.sreq && cur_q.hold && !wr_hit |=> cur_q.sreq); // R5
  AST_AREQ_HELD_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.areq && cur_q.hold && !wr_hit |=> cur_q.areq); // R9
  AST_AREQ_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode_i && cur_q.areq && !ack_i && !wr_hit |=> cur_q.areq); // R8
  AST_REQ_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && !ack_i |=> req_q); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cur_q.sreq == $past(wdata_i[SREQ_BIT]))); // R10
  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur_q.hold) && !wr_hit && !async_mode_i |=> (!cur_q.sreq && !cur_q.areq)); // R6
endmodule

// File: rtl/psc_sync_ctrl.sv
`timescale 1ns/1ps
module psc_sync_ctrl
  import psc_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned SYNC_N   = 4,
  parameter int unsigned ASYNC_N  = 6,
  parameter int unsigned SYNC_FF  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               aclk,
  input  logic               arst_n,
  input  logic               bus_io_sel,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic               async_mode_i,
  output logic               sync_psc_rst_o,
  output logic [SYNC_N-1:0]  sync_tick_o,
  output logic               async_psc_rst_o,
  output logic [ASYNC_N-1:0] async_tick_o
);
  localparam logic [SYNC_N*8-1:0]  SYNC_TAPS  = {8'd10, 8'd8, 8'd6, 8'd3};
  localparam logic [ASYNC_N*8-1:0] ASYNC_TAPS = {8'd10, 8'd8, 8'd7, 8'd6, 8'd5, 8'd3};

  logic s_rst_n, a_rst_n;
  logic req_s, req_a, ack_a_q, ack_s;
  logic sreq;

  psc_rst_sync #(.STAGES(SYNC_FF)) u_rst_s (
    .clk(clk), .rst_n(rst_n), .rst_n_o(s_rst_n));
  psc_rst_sync #(.STAGES(SYNC_FF)) u_rst_a (
    .clk(aclk), .rst_n(arst_n), .rst_n_o(a_rst_n));

  psc_ctl_reg u_reg (
    .clk          (clk),
    .rst_n        (s_rst_n),
    .io_sel_i     (bus_io_sel),
    .addr_i       (bus_addr),
    .we_i         (bus_we),
    .wdata_i      (bus_wdata),
    .rdata_o      (bus_rdata),
    .async_mode_i (async_mode_i),
    .ack_i        (ack_s),
    .req_o        (req_s),
    .sreq_o       (sreq)
  );

  // request into the prescaler clock domain
  psc_cdc_sync #(.W(1), .STAGES(SYNC_FF)) u_req_sync (
    .clk(aclk), .rst_n(a_rst_n), .d_i(req_s), .q_o(req_a));

  // acknowledge: the prescaler has spent an aclk edge in reset
  always_ff @(posedge aclk or negedge a_rst_n) begin
    if (!a_rst_n) ack_a_q <= 1'b0;
    else          ack_a_q <= req_a;
  end

  psc_cdc_sync #(.W(1), .STAGES(SYNC_FF)) u_ack_sync (
    .clk(clk), .rst_n(s_rst_n), .d_i(ack_a_q), .q_o(ack_s));

  psc_counter #(.CNT_W(CNT_W), .NTAP(SYNC_N), .TAP_LOG2(SYNC_TAPS)) u_cnt_s (
    .clk(clk), .rst_n(s_rst_n), .clr_i(sreq), .tick_o(sync_tick_o));

  psc_counter #(.CNT_W(CNT_W), .NTAP(ASYNC_N), .TAP_LOG2(ASYNC_TAPS)) u_cnt_a (
    .clk(aclk), .rst_n(a_rst_n), .clr_i(req_a), .tick_o(async_tick_o));

  assign sync_psc_rst_o  = sreq;
  assign async_psc_rst_o = req_a;

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge aclk) disable iff (!a_rst_n)
    req_a |=> ack_a_q); // R8
  AST_SYNC_RST_QUIETS_TAPS: assert property (@(posedge clk) disable iff (!s_rst_n)
    sync_psc_rst_o |=> (sync_tick_o == '0)); // R4
endmodule

// File: tb/sim_psc_sync_ctrl.sv
`timescale 1ns/1ps
module sim_psc_sync_ctrl;
  logic        clk = 1'b0, aclk = 1'b0;
  logic        rst_n = 1'b0, arst_n = 1'b0;
  logic        io_sel = 1'b0, we = 1'b0, amode = 1'b0;
  logic [15:0] addr = 16'h0043;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        s_rst, a_rst;
  logic [3:0]  s_tick;
  logic [5:0]  a_tick;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  // reference model state
  bit m_hold, m_areq, m_sreq, last_hit, prev_hold;
  int m_cnt, m_wait;
  int a_cnt, a_wait;
  bit a_obs, seen_arst;
  int a_tick_top;
  int sdiv[4] = '{8, 64, 256, 1024};
  int adiv[6] = '{8, 32, 64, 128, 256, 1024};

  always #2 clk  = ~clk;   // 250 MHz
  always #7 aclk = ~aclk;

  psc_sync_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .aclk(aclk), .arst_n(arst_n),
    .bus_io_sel(io_sel), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .async_mode_i(amode),
    .sync_psc_rst_o(s_rst), .sync_tick_o(s_tick),
    .async_psc_rst_o(a_rst), .async_tick_o(a_tick));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit decodes(input logic [15:0] a, input logic io);
    return io ? (a == 16'h0023) : (a == 16'h0043);
  endfunction

  function automatic logic [7:0] model_read();
    if (!decodes(addr, io_sel)) return 8'h00;
    return {m_hold, 5'b0, m_areq, m_sreq};
  endfunction

  // system-domain model, updated at every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 0; m_areq = 0; m_sreq = 0; m_cnt = 0; m_wait = 2;
      last_hit = 0; prev_hold = 0;
    end else if (m_wait > 0) begin
      m_wait--;
    end else begin
      bit h, oh, os;
      h  = we && decodes(addr, io_sel);
      oh = m_hold; os = m_sreq;
      m_cnt = os ? 0 : (m_cnt + 1) % 1024;
      if (h) begin
        m_hold = wdata[7]; m_areq = wdata[1]; m_sreq = wdata[0];
        if (wdata[1]) seen_arst = 0;
      end else if (!oh) begin
        m_sreq = 0;
        if (!amode) m_areq = 0;
      end
      last_hit = h; prev_hold = oh;
    end
  end

  // compare on every system clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_areq && amode && !last_hit && !prev_hold && decodes(addr, io_sel) && rdata[1] == 1'b0) begin
        chk(seen_arst || a_rst, "R8 bit1 cleared only after async reset seen", {31'b0, seen_arst}, 1);
        m_areq = 0;
      end
      chk(rdata == model_read(), "R3 R5 R9 R10 register readback", rdata, model_read());
      chk(s_rst == m_sreq, "R3 R5 sync prescaler reset", s_rst, m_sreq);
      for (int i = 0; i < 4; i++) begin
        bit e;
        e = ((m_cnt % sdiv[i]) == sdiv[i] - 1);
        chk(s_tick[i] == e, "R4 sync tick", s_tick[i], e);
      end
    end
  end

  // asynchronous-domain model
  always @(negedge aclk) begin
    a_obs = a_rst;
    if (a_obs) seen_arst = 1;
    if (arst_n && a_wait == 0) begin
      for (int i = 0; i < 6; i++) begin
        bit e;
        e = ((a_cnt % adiv[i]) == adiv[i] - 1);
        chk(a_tick[i] == e, "R12 async tick", a_tick[i], e);
      end
      if (a_tick[5]) a_tick_top++;
    end
  end

  always @(posedge aclk) begin
    if (!arst_n) begin a_cnt = 0; a_wait = 2; end
    else if (a_wait > 0) a_wait--;
    else a_cnt = a_obs ? 0 : (a_cnt + 1) % 1024;
  end

  task automatic wr_at(input logic [15:0] a, input logic io, input logic [7:0] d);
    @(negedge clk); #1;
    we = 1; addr = a; io_sel = io; wdata = d;
    @(negedge clk); #1;
    we = 0; addr = 16'h0043; io_sel = 0; wdata = 8'h00;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_at(16'h0043, 1'b0, d);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #600000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    #1;
    chk(rdata == 8'h00, "R1 readback in reset", rdata, 8'h00);
    step(5);
    rst_n = 1; arst_n = 1;
    step(3);
    chk(rdata == 8'h00, "R1 readback after reset", rdata, 8'h00);
    step(1100);                                   // R4 free-running taps

    wr(8'h01);
    chk(s_rst == 1'b1, "R3 sync reset pulse high", s_rst, 1);
    chk(rdata == 8'h01, "R3 bit0 reads one", rdata, 8'h01);
    step(1);
    chk(s_rst == 1'b0, "R3 sync reset pulse ends", s_rst, 0);
    step(20);

    wr(8'h7C);
    chk(rdata == 8'h00, "R11 unused bits ignored", rdata, 8'h00);
    step(2);
    chk(rdata == 8'h00, "R11 unused bits still zero", rdata, 8'h00);

    wr_at(16'h0023, 1'b1, 8'h01);
    chk(s_rst == 1'b1, "R2 write through I/O alias", s_rst, 1);
    step(3);
    wr_at(16'h0044, 1'b0, 8'h81);
    chk(rdata == 8'h00, "R2 neighbour address ignored", rdata, 8'h00);
    wr_at(16'h0043, 1'b1, 8'h81);
    chk(rdata == 8'h00, "R2 wrong space ignored", rdata, 8'h00);
    addr = 16'h0044; #1;
    chk(rdata == 8'h00, "R2 unmapped read zero", rdata, 8'h00);
    addr = 16'h0043;
    step(3);

    // R10: second write coincides with the self-clear
    @(negedge clk); #1; we = 1; wdata = 8'h01;
    step(1);
    chk(s_rst == 1'b1, "R10 first write", s_rst, 1);
    @(negedge clk); #1; we = 0; wdata = 8'h00;
    chk(s_rst == 1'b1, "R10 write beats self-clear", s_rst, 1);
    step(1);
    chk(s_rst == 1'b0, "R10 clears afterwards", s_rst, 0);
    step(20);

    amode = 1;
    wr(8'h83);
    step(300);
    chk(rdata == 8'h83, "R9 bits held in hold mode (async)", rdata, 8'h83);
    chk(s_rst == 1'b1, "R5 sync reset held", s_rst, 1);
    amode = 0;
    step(50);
    chk(rdata == 8'h83, "R9 bits held in hold mode (sync)", rdata, 8'h83);
    amode = 1;
    step(5);

    wr(8'h03);
    chk(rdata == 8'h03, "R6 release write lands", rdata, 8'h03);
    step(1);
    chk(rdata == 8'h00, "R6 both bits clear together", rdata, 8'h00);
    chk(s_rst == 1'b0, "R6 sync reset released", s_rst, 0);
    step(40);

    wr(8'h02);
    chk(rdata == 8'h02, "R8 request set", rdata, 8'h02);
    step(2);
    chk(rdata[1] == 1'b1, "R8 request waits for far domain", rdata[1], 1);
    for (int k = 0; k < 80 && rdata[1]; k++) step(1);
    chk(rdata[1] == 1'b0, "R8 request cleared by hardware", rdata[1], 0);
    chk(seen_arst, "R8 async reset observed", {31'b0, seen_arst}, 1);
    step(40);

    amode = 0;
    step(2);
    wr(8'h02);
    chk(rdata == 8'h02, "R7 request set", rdata, 8'h02);
    step(1);
    chk(rdata == 8'h00, "R7 request cleared at once", rdata, 8'h00);
    step(40);
    chk(seen_arst, "R7 async prescaler still reset", {31'b0, seen_arst}, 1);

    step(4000);                                   // R12 long run of async taps
    chk(a_tick_top > 0, "R12 divide-by-1024 tap seen", a_tick_top, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule